// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the architectural state update a hart makes when it takes an exception or an interrupt. A trap request carries an interrupt flag, a cause number and a faulting address. The unit also reads the current pc, the current privilege, a compact status word, the exception and interrupt delegation masks, and the supervisor and machine trap-vector registers. From these it decides whether the trap is handled at supervisor or machine level. It then produces the new status word, the cause, exception-pc and trap-value values for that level, the new privilege, the next pc, and a pulse that tells the core to drop any load reservation.

The unit is a two-state machine. In `ST_IDLE` it waits for a request. The transition `accept` (request high in `ST_IDLE`) registers every result and moves to `ST_COMMIT`. `ST_COMMIT` lasts exactly one cycle and asserts `done_o`. The transition `retire` then always returns to `ST_IDLE`. The results stay on the outputs until the next accepted request. The core writes them into its own registers during the `done_o` cycle, using `to_super_o` to pick the level.

Status word layout, used by every status port: bit 0 supervisor enable, bit 1 machine enable, bit 2 supervisor previous-enable, bit 3 machine previous-enable, bit 4 supervisor previous-privilege, bits 6:5 machine previous-privilege. Privilege encoding: 0 user, 1 supervisor, 3 machine.

Top module: `trap_entry_unit`

## Requirements
- R1: The trap targets supervisor level (`to_super_o`=1, `new_priv_o`=1) when the current privilege is 0 or 1 and the delegation bit indexed by the effective cause is set. That bit is taken from `ideleg_i` for interrupts and from `edeleg_i` for exceptions. In every other case the target is machine level (`to_super_o`=0, `new_priv_o`=3).
- R2: On supervisor entry, status bit 2 takes the old bit 0, bit 4 takes bit 0 of the current privilege, and bit 0 is cleared. All other status bits are unchanged.
- R3: On machine entry, status bit 3 takes the old bit 1, bits 6:5 take the current privilege, and bit 1 is cleared. All other status bits are unchanged.
- R4: `cause_o` holds the effective cause in its low bits. Its most significant bit equals the interrupt flag, and all bits in between are zero.
- R5: `epc_o` equals the pc of the trapping request.
- R6: `next_pc_o` is the selected trap-vector register (the supervisor one for supervisor targets, the machine one otherwise) with bits 1:0 cleared.
- R7: When the request is an interrupt and the selected vector register has bits 1:0 equal to 1, `next_pc_o` also adds 4 times the effective cause. Exceptions never add this offset, whatever the mode bits are.
- R8: `tval_o` equals the faulting address for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is zero for every other exception cause and for every interrupt.
- R9: An exception with cause 8, 9 or 11 is an environment call. Its effective cause becomes 8 from user, 9 from supervisor and 11 from machine, and that remapped cause drives delegation, `cause_o` and `next_pc_o`.
- R10: `resv_clear_o` is high during the `done_o` cycle exactly when `new_priv_o` differs from the privilege at the request.
- R11: A request accepted at a clock edge gives `done_o` high for exactly the following cycle, with all results valid then. The results hold until the next accepted request.
- R12: A request present while `done_o` is high is ignored: the outputs keep their values through the next cycle.
- R13: After reset, `done_o` and `resv_clear_o` are 0, `new_priv_o` is 3, and the status, cause, epc, tval and next-pc outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Trap request |
| irq_i | input | 1 | Request is an interrupt |
| cause_i | input | CW | Raw cause number |
| addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | Current pc |
| priv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status word |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| done_o | output | 1 | Results valid, one-cycle pulse |
| to_super_o | output | 1 | Target level is supervisor |
| new_priv_o | output | 2 | Privilege after the trap |
| status_o | output | 7 | Updated status word |
| cause_o | output | XLEN | Cause value to write |
| epc_o | output | XLEN | Exception pc to write |
| tval_o | output | XLEN | Trap value to write |
| next_pc_o | output | XLEN | Handler address |
| resv_clear_o | output | 1 | Invalidate load reservation |

## Verification
The hardest situation to reach is the one where several rules interact: an environment call whose remapped cause selects a different delegation bit than the raw cause would, combined with a vector register in vectored mode that must still give no offset because the request is an exception. The bench reaches it by sweeping every raw cause from 0 to 15 against all three privileges, both request kinds, both vector modes and three delegation masks. One of those masks delegates only some causes, so a wrong cause index shows up as a wrong target level. A request held through the `done_o` cycle with changed inputs exercises the ignore rule.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef struct packed {
        logic [1:0] m_prev_priv;
        logic       s_prev_priv;
        logic       m_prev_en;
        logic       s_prev_en;
        logic       m_en;
        logic       s_en;
    } status_t;

    typedef enum logic {
        ST_IDLE,
        ST_COMMIT
    } fsm_e;

    function automatic logic is_env_call(input logic [7:0] c);
        return (c == 8'd8) || (c == 8'd9) || (c == 8'd11);
    endfunction

    function automatic logic captures_addr(input logic [7:0] c);
        case (c)
            8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd12, 8'd13, 8'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN)
) (
    input  logic            irq_i,
    input  logic [CW-1:0]   cause_i,
    input  logic [1:0]      priv_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] ideleg_i,
    output logic [CW-1:0]   cause_o,
    output logic            to_super_o
);
    logic [7:0] wide_cause;
    logic       low_priv;
    logic       sel_bit;

    always_comb begin
        wide_cause = 8'(cause_i);
        cause_o    = cause_i;
        if (!irq_i && is_env_call(wide_cause)) begin
            unique case (priv_i)
                PRIV_U:  cause_o = CW'(8);
                PRIV_S:  cause_o = CW'(9);
                default: cause_o = CW'(11);
            endcase
        end
        low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        sel_bit    = irq_i ? ideleg_i[cause_o] : edeleg_i[cause_o];
        to_super_o = low_priv && sel_bit;
    end
endmodule

// File: rtl/trap_status_next.sv
module trap_status_next
    import trap_pkg::*;
(
    input  status_t    status_i,
    input  logic [1:0] priv_i,
    input  logic       to_super_i,
    output status_t    status_o
);
    always_comb begin
        status_o = status_i;
        if (to_super_i) begin
            status_o.s_prev_en   = status_i.s_en;
            status_o.s_prev_priv = priv_i[0];
            status_o.s_en        = 1'b0;
        end else begin
            status_o.m_prev_en   = status_i.m_en;
            status_o.m_prev_priv = priv_i;
            status_o.m_en        = 1'b0;
        end
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] tvec_i,
    input  logic            irq_i,
    input  logic [CW-1:0]   cause_i,
    output logic [XLEN-1:0] pc_o
);
    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec_i[XLEN-1:2], 2'b00};
        offset = '0;
        if (irq_i && (tvec_i[1:0] == MODE_VECTORED)) begin
            offset = {{(XLEN-CW-2){1'b0}}, cause_i, 2'b00};
        end
        pc_o = base + offset;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            irq_i,
    input  logic [CW-1:0]   cause_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [1:0]      priv_i,
    input  logic [6:0]      status_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] ideleg_i,
    input  logic [XLEN-1:0] stvec_i,
    input  logic [XLEN-1:0] mtvec_i,
    output logic            done_o,
    output logic            to_super_o,
    output logic [1:0]      new_priv_o,
    output logic [6:0]      status_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] tval_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            resv_clear_o
);
    fsm_e state_q, state_d;

    logic [CW-1:0]   eff_cause;
    logic            to_super;
    status_t         status_nx;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] cause_word;
    logic [XLEN-1:0] tval_nx;
    logic [1:0]      priv_nx;
    logic            accept;

    trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
        .irq_i      (irq_i),
        .cause_i    (cause_i),
        .priv_i     (priv_i),
        .edeleg_i   (edeleg_i),
        .ideleg_i   (ideleg_i),
        .cause_o    (eff_cause),
        .to_super_o (to_super)
    );

    trap_status_next u_status (
        .status_i   (status_t'(status_i)),
        .priv_i     (priv_i),
        .to_super_i (to_super),
        .status_o   (status_nx)
    );

    trap_vector #(.XLEN(XLEN), .CW(CW)) u_vector (
        .tvec_i  (to_super ? stvec_i : mtvec_i),
        .irq_i   (irq_i),
        .cause_i (eff_cause),
        .pc_o    (vec_pc)
    );

    always_comb begin
        cause_word = {irq_i, {(XLEN-CW-1){1'b0}}, eff_cause};
        tval_nx    = (!irq_i && captures_addr(8'(eff_cause))) ? addr_i : '0;
        priv_nx    = to_super ? PRIV_S : PRIV_M;
        accept     = req_i && (state_q == ST_IDLE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_super_o   <= 1'b0;
            new_priv_o   <= PRIV_M;
            status_o     <= '0;
            cause_o      <= '0;
            epc_o        <= '0;
            tval_o       <= '0;
            next_pc_o    <= '0;
            resv_clear_o <= 1'b0;
        end else begin
            resv_clear_o <= 1'b0;
            if (accept) begin
                to_super_o   <= to_super;
                new_priv_o   <= priv_nx;
                status_o     <= 7'(status_nx);
                cause_o      <= cause_word;
                epc_o        <= pc_i;
                tval_o       <= tval_nx;
                next_pc_o    <= vec_pc;
                resv_clear_o <= (priv_nx != priv_i);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        done_o = (state_q == ST_COMMIT);
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic            irq_i,
    input logic [1:0]      priv_i,
    input logic            done_o,
    input logic            to_super_o,
    input logic [1:0]      new_priv_o,
    input logic [6:0]      status_o,
    input logic [XLEN-1:0] cause_o,
    input logic [XLEN-1:0] tval_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            resv_clear_o
);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !done_o) |=> done_o);

    // R1
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(priv_i) == 2'd3) |-> (new_priv_o == 2'd3 && !to_super_o));

    // R2
    super_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && to_super_o) |-> !status_o[0]);

    // R3
    machine_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !to_super_o) |-> !status_o[1]);

    // R4
    cause_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cause_o[XLEN-1] == $past(irq_i)));

    // R8
    irq_tval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(irq_i)) |-> (tval_o == '0));

    // R7
    exc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(irq_i)) |-> (next_pc_o[1:0] == 2'b00));

    // R10
    resv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (resv_clear_o == (new_priv_o != $past(priv_i))));

    // R10
    resv_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear_o |-> done_o);
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .irq_i        (irq_i),
    .priv_i       (priv_i),
    .done_o       (done_o),
    .to_super_o   (to_super_o),
    .new_priv_o   (new_priv_o),
    .status_o     (status_o),
    .cause_o      (cause_o),
    .tval_o       (tval_o),
    .next_pc_o    (next_pc_o),
    .resv_clear_o (resv_clear_o)
);

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
    localparam int XLEN = 32;
    localparam int CW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic            irq_i = 1'b0;
    logic [CW-1:0]   cause_i = '0;
    logic [XLEN-1:0] addr_i = '0;
    logic [XLEN-1:0] pc_i = '0;
    logic [1:0]      priv_i = 2'd3;
    logic [6:0]      status_i = '0;
    logic [XLEN-1:0] edeleg_i = '0;
    logic [XLEN-1:0] ideleg_i = '0;
    logic [XLEN-1:0] stvec_i = '0;
    logic [XLEN-1:0] mtvec_i = '0;
    logic            done_o, to_super_o, resv_clear_o;
    logic [1:0]      new_priv_o;
    logic [6:0]      status_o;
    logic [XLEN-1:0] cause_o, epc_o, tval_o, next_pc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CW(CW)) u_trap_entry_unit (.*);

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff_cause(input bit irq, input int c, input int p);
        if (!irq && (c == 8 || c == 9 || c == 11))
            return (p == 0) ? 8 : (p == 1) ? 9 : 11;
        return c;
    endfunction

    function automatic bit addr_cause(input int c);
        return c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
               c == 12 || c == 13 || c == 15;
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] delegs [3];
        int pv [3];
        int n = 0;
        delegs[0] = 32'h0000_0000;
        delegs[1] = 32'hFFFF_FFFF;
        delegs[2] = 32'h0000_A2B5;
        pv[0] = 0; pv[1] = 1; pv[2] = 3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 done", XLEN'(done_o), 0);
        check("R13 priv", XLEN'(new_priv_o), 3);
        check("R13 resv", XLEN'(resv_clear_o), 0);
        check("R13 status", XLEN'(status_o), 0);
        check("R13 cause", cause_o, 0);
        check("R13 next_pc", next_pc_o, 0);

        for (int d = 0; d < 3; d++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int irq = 0; irq < 2; irq++) begin
                    for (int vm = 0; vm < 2; vm++) begin
                        for (int c = 0; c < 16; c++) begin
                            int p, ec;
                            bit sup;
                            logic [6:0] st, es;
                            logic [XLEN-1:0] tv, npc;
                            p  = pv[pi];
                            n++;
                            st = 7'(n * 37 + 3);
                            req_i    = 1'b1;
                            irq_i    = irq[0];
                            cause_i  = CW'(c);
                            priv_i   = 2'(p);
                            status_i = st;
                            pc_i     = 32'h8000_0000 + XLEN'(n * 4);
                            addr_i   = 32'h1234_0000 ^ XLEN'(n);
                            edeleg_i = delegs[d];
                            ideleg_i = ~delegs[d];
                            stvec_i  = 32'h4000_0100 | XLEN'(vm);
                            mtvec_i  = 32'h2000_0200 | XLEN'(vm) | 32'h0000_0002 * XLEN'(n % 2 == 0 && vm == 0);
                            @(posedge clk);
                            @(negedge clk);
                            ec  = eff_cause(irq[0], c, p);
                            sup = (p != 3) && (irq[0] ? ideleg_i[ec] : edeleg_i[ec]);
                            es  = st;
                            if (sup) begin
                                es[2] = st[0]; es[4] = 1'(p); es[0] = 1'b0;
                            end else begin
                                es[3] = st[1]; es[6:5] = 2'(p); es[1] = 1'b0;
                            end
                            tv  = sup ? stvec_i : mtvec_i;
                            npc = {tv[XLEN-1:2], 2'b00};
                            if (irq[0] && tv[1:0] == 2'd1) npc = npc + XLEN'(ec * 4);
                            check("R11 done", XLEN'(done_o), 1);
                            check("R1 target", XLEN'(to_super_o), XLEN'(sup));
                            check("R1 priv", XLEN'(new_priv_o), sup ? 1 : 3);
                            check(sup ? "R2 status" : "R3 status", XLEN'(status_o), XLEN'(es));
                            check("R4 R9 cause", cause_o, {irq[0], 26'd0, 5'(ec)});
                            check("R5 epc", epc_o, pc_i);
                            check((irq[0] && vm == 1) ? "R7 next_pc" : "R6 next_pc", next_pc_o, npc);
                            check("R8 tval", tval_o, (!irq[0] && addr_cause(ec)) ? addr_i : '0);
                            check("R10 resv", XLEN'(resv_clear_o), XLEN'((sup ? 1 : 3) != p));
                            if (n == 5) begin
                                // R12: request held through done with new inputs is ignored
                                logic [XLEN-1:0] old_c, old_e, old_pc;
                                old_c = cause_o; old_e = epc_o; old_pc = next_pc_o;
                                cause_i = CW'(3);
                                pc_i    = 32'hDEAD_0000;
                                irq_i   = ~irq_i;
                                @(negedge clk);
                                check("R12 done", XLEN'(done_o), 0);
                                check("R12 cause", cause_o, old_c);
                                check("R12 epc", epc_o, old_e);
                                check("R12 next_pc", next_pc_o, old_pc);
                                req_i = 1'b0;
                            end else begin
                                req_i = 1'b0;
                                @(negedge clk);
                                // R11 results held after the pulse
                                check("R11 done low", XLEN'(done_o), 0);
                                check("R11 hold", epc_o, pc_i);
                            end
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule